// File: doc/BRIEF.md
# Masked Configuration Header Register File

This block holds the configuration space of a PCI-style endpoint as a byte array of `CFG_BYTES` entries (up to 256). One access port carries a byte offset, a byte count of 1 to 4 and a 32-bit little-endian data word. While the write strobe is high, each addressed byte is updated through a writable-bit mask that depends on its address. Read-only bits keep their stored value. The high status byte clears a bit only where a 1 is written. Bytes beyond the 64-byte header take the written value unchanged.

Read data is combinational and depends only on the offset and the count. A write that is accepted shows up on the read port in the next cycle. An access with an illegal size or range is rejected, and it raises a one-cycle error flag if it was a write. Reset loads a default image given as a parameter, then applies fixed adjustments: the command enables are cleared, and the upper BAR dwords and the expansion ROM dword are zeroed.

Top module: `cfg_hdr_regs`

## Requirements
- R1: While reset is held, every byte takes its value from `INIT_IMAGE` (byte k at bits 8k+7:8k), with these adjustments: bits 2:0 of byte 0x00 are cleared, and bytes 0x14-0x17, 0x1C-0x27 and 0x30-0x33 are set to zero.
- R2: `rdData` bits 8i+7:8i show the byte at `accOfs+i` for each lane i below `accCnt`. Lanes at or above `accCnt` read zero, and a rejected access reads all zero.
- R3: All bits of byte 0x00 are writable. Only bits 2:0 of byte 0x01 are writable.
- R4: Byte 0x02 is read-only.
- R5: Byte 0x03 uses mask 0xF9 and is write-one-to-clear. A written 1 in a mask bit clears that stored bit, a written 0 leaves it as it is, and bits 1 and 2 never change.
- R6: Bytes 0x0C, 0x10 to 0x27 and 0x3C are fully writable. Every other byte below 0x40 that no other requirement names is read-only.
- R7: The ROM dword at 0x30-0x33 has byte masks 0x01, 0xF8, 0xFF and 0xFF. A masked byte stores (old & ~mask) | (new & mask).
- R8: A 4-byte write at offset 0x30 whose data has bits 31:11 all set leaves the ROM dword reading zero.
- R9: Bytes from 0x40 up to `CFG_BYTES-1` store the written value without any mask.
- R10: An access is rejected when `accCnt` is 0, when it is above 4, or when `accOfs+accCnt` exceeds `CFG_BYTES`. A rejected write raises `errFlag` in the same cycle as the strobe, for that cycle only, and changes no byte.
- R11: An accepted write is visible on `rdData` one clock after its strobe. Within one multi-byte write, each lane applies the mask of its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | Write request for the current access |
| accOfs | input | $clog2(CFG_BYTES) | Byte offset of the access |
| accCnt | input | 3 | Number of bytes, legal values 1 to 4 |
| wrData | input | 32 | Write data, lane 0 in bits 7:0 |
| rdData | output | 32 | Read data for the addressed bytes |
| errFlag | output | 1 | Pulse for a rejected write |

## Verification
The bench builds the block with `CFG_BYTES` set to 128 and a computed default image in which almost every byte is nonzero. With that image, a cleared command bit, a zeroed BAR byte or a read-only bit that changed by mistake all show up as a visible difference. The 128-byte space puts the end-of-space rejection and the unmasked region above the header close enough for random offsets to hit them often. Directed writes cover the status clear-on-one byte, the ROM sizing pattern and writes that cross a mask boundary.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int unsigned LANES = 4;
  localparam logic [7:0] STAT_HI_ADDR = 8'h03;
  localparam logic [7:0] ROM_ADDR = 8'h30;
  localparam logic [7:0] IRQ_LINE_ADDR = 8'h3C;
  localparam logic [7:0] HDR_END = 8'h40;
  localparam logic [31:0] ROM_SIZE_BITS = 32'hFFFF_F800;

  typedef struct packed {
    logic [LANES-1:0] laneEn;
    logic romZero;
    logic accOk;
  } wrCtl_t;

  // writable bits of one configuration byte
  function automatic logic [7:0] hdrMask(input logic [7:0] a);
    logic [7:0] m;
    if (a >= HDR_END) return 8'hFF;
    case (a)
      8'h00: m = 8'hFF;
      8'h01: m = 8'h07;
      8'h03: m = 8'hF9;
      8'h0C: m = 8'hFF;
      8'h30: m = 8'h01;
      8'h31: m = 8'hF8;
      8'h32, 8'h33: m = 8'hFF;
      8'h3C: m = 8'hFF;
      default: m = (a >= 8'h10 && a < 8'h28) ? 8'hFF : 8'h00;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 256,
  localparam int unsigned AW = $clog2(CFG_BYTES)
) (
  input  logic          wrStrobe,
  input  logic [AW-1:0] accOfs,
  input  logic [2:0]    accCnt,
  input  logic [31:0]   wrData,
  output wrCtl_t        ctl,
  output logic          errPulse
);
  logic [AW:0] endPos;
  logic sizeOk, rangeOk;

  always_comb begin
    endPos  = {1'b0, accOfs} + (AW+1)'(accCnt);
    sizeOk  = (accCnt != 3'd0) && (accCnt <= 3'd4);
    rangeOk = endPos <= (AW+1)'(CFG_BYTES);
    ctl.accOk = sizeOk && rangeOk;
    ctl.romZero = wrStrobe && ctl.accOk && (accOfs == AW'(ROM_ADDR)) &&
                  (accCnt == 3'd4) && ((wrData & ROM_SIZE_BITS) == ROM_SIZE_BITS);
    errPulse = wrStrobe && !ctl.accOk;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ctl.laneEn[i] = wrStrobe && ctl.accOk && (3'(i) < accCnt);
  end
endmodule

// File: rtl/cfg_hdr_dp.sv
module cfg_hdr_dp
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 256,
  parameter logic [CFG_BYTES*8-1:0] INIT_IMAGE = '0,
  localparam int unsigned AW = $clog2(CFG_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  wrCtl_t        ctl,
  input  logic [AW-1:0] accOfs,
  input  logic [2:0]    accCnt,
  input  logic [31:0]   wrData,
  output logic [31:0]   rdData
);
  logic [7:0] cfgMem [CFG_BYTES];
  logic [AW-1:0] laneAddr [LANES];
  logic [7:0] nextByte [LANES];

  function automatic logic [7:0] rstByte(input int k);
    logic [7:0] b;
    b = INIT_IMAGE[8*k +: 8];
    if (k == 0) b = b & 8'hF8;
    if ((k >= 'h14 && k < 'h18) || (k >= 'h1C && k < 'h28) || (k >= 'h30 && k < 'h34))
      b = 8'h00;
    return b;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] oldB, newB, mskB;
    always_comb begin
      laneAddr[i] = accOfs + AW'(i);
      oldB = cfgMem[laneAddr[i]];
      newB = wrData[8*i +: 8];
      mskB = hdrMask(8'(laneAddr[i]));
      if (8'(laneAddr[i]) == STAT_HI_ADDR)
        nextByte[i] = oldB & ~(newB & mskB);
      else
        nextByte[i] = (oldB & ~mskB) | (newB & mskB);
      rdData[8*i +: 8] = (ctl.accOk && (3'(i) < accCnt)) ? oldB : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < CFG_BYTES; k++) cfgMem[k] <= rstByte(k);
    end else begin
      for (int i = 0; i < LANES; i++)
        if (ctl.laneEn[i]) cfgMem[laneAddr[i]] <= nextByte[i];
      if (ctl.romZero)
        for (int j = 0; j < 4; j++) cfgMem[int'(ROM_ADDR) + j] <= 8'h00;
    end
  end

  // R4: low status byte never changes
  assert_status_lo_ro_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(cfgMem[2]));
  // R5: high status byte bits can only clear, bits 1 and 2 fixed
  assert_status_w1c_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cfgMem[3] & ~$past(cfgMem[3])) == 8'h00) &&
             (cfgMem[3][2:1] == $past(cfgMem[3][2:1])));
  // R3: upper command bits are read-only
  assert_cmd_hi_ro_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(cfgMem[1][7:3]));
  // R7: read-only ROM bits stay zero after reset
  assert_rom_ro_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMem[int'(ROM_ADDR)][7:1] == 7'd0) && (cfgMem[int'(ROM_ADDR)+1][2:0] == 3'd0));
  // R8: sizing pattern empties the ROM dword
  assert_rom_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.romZero |=> (cfgMem[int'(ROM_ADDR)] == 8'h00) && (cfgMem[int'(ROM_ADDR)+3] == 8'h00));
  // R10: without lane strobes the interrupt line byte holds
  assert_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(|ctl.laneEn) |=> $stable(cfgMem[int'(IRQ_LINE_ADDR)]));
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 256,
  parameter logic [CFG_BYTES*8-1:0] INIT_IMAGE = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrStrobe,
  input  logic [$clog2(CFG_BYTES)-1:0] accOfs,
  input  logic [2:0]                   accCnt,
  input  logic [31:0]                  wrData,
  output logic [31:0]                  rdData,
  output logic                         errFlag
);
  wrCtl_t wrCtl;

  cfg_hdr_ctrl #(.CFG_BYTES(CFG_BYTES)) ctrl_i (
    .wrStrobe(wrStrobe), .accOfs(accOfs), .accCnt(accCnt), .wrData(wrData),
    .ctl(wrCtl), .errPulse(errFlag)
  );

  cfg_hdr_dp #(.CFG_BYTES(CFG_BYTES), .INIT_IMAGE(INIT_IMAGE)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(wrCtl), .accOfs(accOfs), .accCnt(accCnt),
    .wrData(wrData), .rdData(rdData)
  );

  // R10: error pulse only ever accompanies a write strobe
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> wrStrobe && (wrCtl.laneEn == '0));
endmodule

// File: tb/cfg_hdr_regs_tb_top.sv
module cfg_hdr_regs_tb_top;
  localparam int unsigned NB = 128;
  localparam int unsigned AW = $clog2(NB);

  function automatic logic [NB*8-1:0] mkImg();
    logic [NB*8-1:0] v;
    for (int k = 0; k < NB; k++) v[8*k +: 8] = 8'(k * 29 + 197);
    return v;
  endfunction
  localparam logic [NB*8-1:0] IMG = mkImg();

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0;
  logic [AW-1:0] accOfs = '0;
  logic [2:0] accCnt = 3'd1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic errFlag;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] mdl [NB];

  always #2.5 clk = ~clk;

  cfg_hdr_regs #(.CFG_BYTES(NB), .INIT_IMAGE(IMG)) dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .accOfs(accOfs), .accCnt(accCnt),
    .wrData(wrData), .rdData(rdData), .errFlag(errFlag)
  );

  function automatic logic [7:0] refMask(input int a);
    if (a >= 64) return 8'hFF;
    if (a == 0 || a == 12 || a == 60 || a == 50 || a == 51) return 8'hFF;
    if (a >= 16 && a <= 39) return 8'hFF;
    if (a == 1) return 8'h07;
    if (a == 3) return 8'hF9;
    if (a == 48) return 8'h01;
    if (a == 49) return 8'hF8;
    return 8'h00;
  endfunction

  function automatic bit refLegal(input int ofs, input int cnt);
    return (cnt >= 1) && (cnt <= 4) && (ofs + cnt <= NB);
  endfunction

  task automatic modelReset();
    for (int k = 0; k < NB; k++) begin
      mdl[k] = IMG[8*k +: 8];
      if (k == 0) mdl[k][2:0] = 3'b000;
      if ((k >= 20 && k <= 23) || (k >= 28 && k <= 39) || (k >= 48 && k <= 51)) mdl[k] = 8'h00;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input int ofs, input int cnt, input logic [31:0] d, input string req);
    bit ok;
    @(negedge clk);
    wrStrobe = 1'b1; accOfs = AW'(ofs); accCnt = 3'(cnt); wrData = d;
    #1;
    ok = refLegal(ofs, cnt);
    check(req, {31'd0, errFlag}, {31'd0, !ok});
    if (ok) begin
      if (ofs == 48 && cnt == 4 && d[31:11] == 21'h1FFFFF) begin
        for (int j = 48; j < 52; j++) mdl[j] = 8'h00;
      end else begin
        for (int i = 0; i < cnt; i++) begin
          logic [7:0] o, n, m;
          o = mdl[ofs+i]; n = d[8*i +: 8]; m = refMask(ofs+i);
          if (ofs + i == 3) mdl[ofs+i] = o & ~(n & m);
          else mdl[ofs+i] = (o & ~m) | (n & m);
        end
      end
    end
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic doRead(input int ofs, input int cnt, input string req);
    logic [31:0] e;
    @(negedge clk);
    wrStrobe = 1'b0; accOfs = AW'(ofs); accCnt = 3'(cnt);
    #1;
    e = '0;
    if (refLegal(ofs, cnt))
      for (int i = 0; i < cnt; i++) e[8*i +: 8] = mdl[ofs+i];
    check(req, rdData, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: full image after reset
    for (int a = 0; a < NB; a += 4) doRead(a, 4, "R1");

    // R2: partial lanes and rejected read
    doRead(5, 3, "R2");
    doRead(NB - 1, 2, "R2");
    doRead(8, 6, "R2");

    // R3: command bytes
    doWrite(0, 2, 32'h0000_FFFF, "R3");
    doRead(0, 2, "R3");
    // R4 and R5: status bytes
    doWrite(2, 2, 32'h0000_FFFF, "R5");
    doRead(2, 2, "R4");
    doWrite(3, 1, 32'h0000_0000, "R5");
    doRead(3, 1, "R5");
    // R6: writable and read-only header bytes
    doWrite(12, 4, 32'hA5A5_A5A5, "R6");
    doRead(12, 4, "R6");
    doWrite(60, 4, 32'h1234_5678, "R6");
    doRead(60, 4, "R6");
    doWrite(4, 4, 32'hFFFF_FFFF, "R6");
    doRead(4, 4, "R6");
    // R7 and R8: ROM dword
    doWrite(48, 4, 32'h1234_5678, "R7");
    doRead(48, 4, "R7");
    doWrite(48, 4, 32'hFFFF_F801, "R8");
    doRead(48, 4, "R8");
    // R9: unmasked bytes above the header
    doWrite(80, 4, 32'hDEAD_BEEF, "R9");
    doRead(80, 4, "R9");
    doWrite(NB - 4, 4, 32'h0BAD_F00D, "R9");
    doRead(NB - 4, 4, "R9");
    // R10: rejected writes change nothing
    doWrite(60, 0, 32'hFFFF_FFFF, "R10");
    doWrite(60, 5, 32'hFFFF_FFFF, "R10");
    doWrite(NB - 2, 4, 32'hFFFF_FFFF, "R10");
    doRead(60, 4, "R10");
    doRead(NB - 4, 4, "R10");
    // R11: a write crossing mask boundaries
    doWrite(38, 4, 32'h5566_7788, "R11");
    doRead(36, 4, "R11");
    doRead(40, 4, "R11");

    // R11: constrained random mix
    for (int n = 0; n < 600; n++) begin
      int ofs, cnt;
      logic [31:0] d;
      ofs = ($urandom % 4 == 0) ? int'($urandom % NB) : int'($urandom % 72);
      cnt = ($urandom % 8 == 0) ? int'($urandom % 8) : int'($urandom % 4) + 1;
      d = $urandom;
      if ($urandom % 16 == 0) begin ofs = 48; cnt = 4; d = d | 32'hFFFF_F800; end
      doWrite(ofs, cnt, d, "R11");
      doRead(ofs, cnt, "R11");
      doRead(int'($urandom % (NB - 3)), 4, "R11");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule